// File: doc/BRIEF.md
# UART Receive Character Queue with Per-Character Error Tags

This block sits between the receive shifter of a serial port and the host bus. Each character that arrives from the shifter carries three error flags: parity, framing and break. The block stores the byte and its flags together as one entry. The host sees the oldest unread byte through a read-only holding output. A line-status vector shows that byte's flags, a data-ready bit and a sticky overrun bit.

With the queue enable set, up to 16 characters are buffered. A receive-data interrupt is raised once the fill count reaches a level chosen from four settings. With the enable clear, the block holds a single character and interrupts as soon as it has one. Dropping the enable empties the block.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset `hold_data` is 0, every bit of `line_status` is 0 and `rx_irq` is 0.
- R2: With `q_enable` = 1, up to 16 characters are held. `hold_data` shows the oldest unread one. A pulse on `rd_hold` while a character is held removes it, and the next one shows from the following cycle.
- R3: `line_status[2]` is the parity flag, `[3]` the framing flag and `[4]` the break flag of the character at the head. They follow a new head in the cycle after the read. They and `hold_data` read 0 when nothing is held.
- R4: `line_status[0]` is 1 exactly when at least one character is held.
- R5: A character that arrives with no room and no read in the same cycle is dropped and sets `line_status[1]`. Room is 16 entries with the enable set and 1 with it clear. Stored characters are not changed.
- R6: `line_status[1]` stays set until a pulse on `rd_status` clears it. If a drop happens in the same cycle as that pulse, the bit stays set.
- R7: When the block is full, an arrival in the same cycle as a `rd_hold` read is accepted into the slot the read frees.
- R8: With `q_enable` = 1, `rx_irq` is 1 while the fill count is at or above the level selected by `trig_sel` (0→1, 1→4, 2→8, 3→14), and 0 below it.
- R9: With `q_enable` = 0, the block holds one character and `rx_irq` is 1 exactly while that character is held.
- R10: A cycle in which `q_enable` goes from 1 to 0 empties the block, clears overrun and discards any arrival in that cycle.
- R11: A `rd_hold` pulse while empty changes nothing. A following single arrival is the only character held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_enable | input | 1 | 1 = queued mode, 0 = single-register mode |
| trig_sel | input | 2 | Interrupt fill-level select |
| in_valid | input | 1 | One-cycle strobe: a character is delivered |
| in_data | input | 8 | Delivered character |
| in_perr | input | 1 | Parity flag of the delivered character |
| in_ferr | input | 1 | Framing flag of the delivered character |
| in_brk | input | 1 | Break flag of the delivered character |
| rd_hold | input | 1 | Host read of the holding output |
| rd_status | input | 1 | Host read of the line status |
| hold_data | output | 8 | Oldest unread character |
| line_status | output | 5 | {break, framing, parity, overrun, data ready} |
| rx_irq | output | 1 | Receive-data interrupt |

## Verification
Two events can fall in the same cycle. One is an arrival together with a host read of the head, including when the block is full, where the read must free room for the arrival. The other is a drop on overrun in the same cycle as a status read, where the set must win over the clear. The bench drives both pairs in a single cycle. A queue-based reference model predicts the head byte, its flags, the overrun bit and the interrupt, and these are compared after every cycle.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    // One stored character: flags above the byte
    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rxq_entry_t;

    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  rxq_entry_t      wdata,
    input  logic [AW-1:0]   raddr,
    output rxq_entry_t      rdata
);

    rxq_entry_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/rxq_level.sv
module rxq_level
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          q_enable,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    output logic          irq
);

    logic [CW-1:0] level;

    always_comb begin
        if (q_enable) begin
            level = CW'(trig_level(trig_sel, DEPTH));
        end else begin
            level = CW'(1);
        end
        irq = (count >= level);
    end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       q_enable,
    input  logic [1:0] trig_sel,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_perr,
    input  logic       in_ferr,
    input  logic       in_brk,
    input  logic       rd_hold,
    input  logic       rd_status,
    output logic [7:0] hold_data,
    output logic [4:0] line_status,
    output logic       rx_irq
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] count;
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic          ovr;
        logic          en_prev;
    } rxq_state_t;

    rxq_state_t    st_d, st_q;
    logic          we;
    rxq_entry_t    wentry, head;
    logic [CW-1:0] cap;
    logic          flush, pop, room, has;
    logic [CW-1:0] count_q;
    logic          en_prev_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        we     = 1'b0;
        wentry = '{brk: in_brk, ferr: in_ferr, perr: in_perr, data: in_data};
        cap    = q_enable ? CW'(DEPTH) : CW'(1);
        flush  = st_q.en_prev && !q_enable;
        pop    = rd_hold && (st_q.count != '0);
        room   = (st_q.count < cap) || pop;

        if (flush) begin
            st_d.count  = '0;
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.ovr    = 1'b0;
        end else begin
            if (pop) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            end
            if (in_valid && room) begin
                we          = 1'b1;
                st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
            end
            st_d.count = st_q.count + CW'(we) - CW'(pop);
            if (in_valid && !room) begin
                st_d.ovr = 1'b1;
            end else if (rd_status) begin
                st_d.ovr = 1'b0;
            end
        end
        st_d.en_prev = q_enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rxq_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (st_q.wr_ptr),
        .wdata (wentry),
        .raddr (st_q.rd_ptr),
        .rdata (head)
    );

    rxq_level #(.DEPTH(DEPTH)) u_level (
        .q_enable (q_enable),
        .trig_sel (trig_sel),
        .count    (st_q.count),
        .irq      (rx_irq)
    );

    assign count_q     = st_q.count;
    assign en_prev_q   = st_q.en_prev;
    assign has         = (st_q.count != '0);
    assign hold_data   = has ? head.data : 8'h00;
    assign line_status = has ? {head.brk, head.ferr, head.perr, st_q.ovr, 1'b1}
                             : {3'b000, st_q.ovr, 1'b0};

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          q_enable,
    input logic          in_valid,
    input logic          rd_hold,
    input logic          rd_status,
    input logic [7:0]    hold_data,
    input logic [4:0]    line_status,
    input logic          rx_irq,
    input logic [CW-1:0] count,
    input logic          en_prev
);

    logic flush;
    assign flush = en_prev && !q_enable;

    p_empty_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_status[0] |-> (line_status[4:2] == 3'b000 && hold_data == 8'h00));

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && count != '0 && !in_valid && !flush) |=> (count == $past(count) - 1'b1));

    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_enable && !flush && in_valid && !rd_hold && count == CW'(DEPTH))
        |=> (line_status[1] && count == CW'(DEPTH)));

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_status[1] && !rd_status && !flush) |=> line_status[1]);

    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_status[1] && rd_status && !in_valid && !flush) |=> !line_status[1]);

    p_single_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_enable && line_status[0]) |-> rx_irq);

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (line_status == 5'b00000 && !rx_irq));

endmodule

bind uart_rx_queue rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_enable    (q_enable),
    .in_valid    (in_valid),
    .rd_hold     (rd_hold),
    .rd_status   (rd_status),
    .hold_data   (hold_data),
    .line_status (line_status),
    .rx_irq      (rx_irq),
    .count       (count_q),
    .en_prev     (en_prev_q)
);

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       q_enable;
    logic [1:0] trig_sel;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_perr, in_ferr, in_brk;
    logic       rd_hold, rd_status;
    logic [7:0] hold_data;
    logic [4:0] line_status;
    logic       rx_irq;

    int checks = 0;
    int errors = 0;

    logic [10:0] exp_q[$];
    bit          ovr_m;
    bit          en_prev_m;

    always #2.5 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .trig_sel(trig_sel),
        .in_valid(in_valid), .in_data(in_data), .in_perr(in_perr),
        .in_ferr(in_ferr), .in_brk(in_brk), .rd_hold(rd_hold),
        .rd_status(rd_status), .hold_data(hold_data),
        .line_status(line_status), .rx_irq(rx_irq)
    );

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, advance the reference model, settle at next negedge
    task automatic step(input bit v, input logic [7:0] d, input logic [2:0] t,
                        input bit rd, input bit rs);
        int  cap;
        bit  pop, room;
        in_valid = v; in_data = d; {in_brk, in_ferr, in_perr} = t;
        rd_hold = rd; rd_status = rs;
        cap = q_enable ? 16 : 1;
        if (en_prev_m && !q_enable) begin
            exp_q.delete();
            ovr_m = 0;
        end else begin
            pop  = rd && (exp_q.size() > 0);
            room = (exp_q.size() < cap) || pop;
            if (pop) void'(exp_q.pop_front());
            if (v && room) exp_q.push_back({t, d});
            if (v && !room) ovr_m = 1;
            else if (rs) ovr_m = 0;
        end
        en_prev_m = q_enable;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; rd_hold = 0; rd_status = 0;
    endtask

    // Monitor side of the scoreboard: compare outputs with the model head
    task automatic check_all(input string tag);
        logic [10:0] e;
        bit          has;
        bit          irq_e;
        has   = exp_q.size() > 0;
        e     = has ? exp_q[0] : 11'h0;
        irq_e = (exp_q.size() >= (q_enable ? lvl_of(trig_sel) : 1));
        chk({tag, " ready"},   line_status[0],   has);
        chk({tag, " data"},    hold_data,        e[7:0]);
        chk({tag, " tags"},    line_status[4:2], e[10:8]);
        chk({tag, " overrun"}, line_status[1],   ovr_m);
        chk({tag, " irq"},     rx_irq,           irq_e);
    endtask

    task automatic drain(input string tag);
        while (exp_q.size() > 0) begin
            step(0, 8'h00, 3'b000, 1, 0);
            check_all(tag);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; q_enable = 1; trig_sel = 0;
        in_valid = 0; in_data = 0; in_perr = 0; in_ferr = 0; in_brk = 0;
        rd_hold = 0; rd_status = 0;
        ovr_m = 0; en_prev_m = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1;
        @(negedge clk);
        en_prev_m = 1;
        check_all("R1");

        // R2 R3 R4: order and per-character tags
        step(1, 8'hA1, 3'b001, 0, 0); check_all("R4");
        step(1, 8'hB2, 3'b010, 0, 0); check_all("R3");
        step(1, 8'hC3, 3'b100, 0, 0); check_all("R2");
        step(1, 8'hD4, 3'b000, 1, 0); check_all("R2");
        drain("R3");

        // R5 R6 R7: full queue, drop, clear, simultaneous read and arrival
        for (int i = 0; i < 16; i++) begin
            step(1, 8'h40 + 8'(i), 3'(i), 0, 0);
            check_all("R2");
        end
        step(1, 8'hEE, 3'b111, 0, 0); check_all("R5");
        step(0, 8'h00, 3'b000, 0, 0); check_all("R6");
        step(0, 8'h00, 3'b000, 0, 1); check_all("R6");
        step(1, 8'h77, 3'b101, 1, 0); check_all("R7");
        step(1, 8'h99, 3'b011, 0, 1); check_all("R6");
        drain("R5");

        // R8: every trigger level while filling and draining
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int k = 0; k < 16; k++) begin
                step(1, 8'(k * 3 + s), 3'(k + s), 0, 0);
                check_all("R8");
            end
            drain("R8");
        end
        step(0, 8'h00, 3'b000, 0, 1); check_all("R8");
        trig_sel = 0;

        // R11: read while empty is ignored
        step(0, 8'h00, 3'b000, 1, 0); check_all("R11");
        step(1, 8'h5A, 3'b110, 0, 0); check_all("R11");
        step(0, 8'h00, 3'b000, 1, 0); check_all("R11");

        // R10: disable flushes, arrival in that cycle dropped
        step(1, 8'h11, 3'b001, 0, 0);
        step(1, 8'h22, 3'b010, 0, 0);
        for (int i = 0; i < 15; i++) step(1, 8'h33, 3'b000, 0, 0);
        check_all("R10");
        q_enable = 0;
        step(1, 8'h44, 3'b100, 0, 0); check_all("R10");

        // R9: single-register mode
        step(1, 8'h61, 3'b010, 0, 0); check_all("R9");
        step(1, 8'h62, 3'b001, 0, 0); check_all("R9");
        step(1, 8'h63, 3'b100, 1, 1); check_all("R9");
        step(0, 8'h00, 3'b000, 1, 0); check_all("R9");

        q_enable = 1;
        step(1, 8'h70, 3'b111, 0, 0); check_all("R2");
        drain("R2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule